// File: doc/BRIEF.md
# Page-Buffered Write and Pointer Engine

This block sits behind the bit-level front-end of a two-wire serial memory target. The front-end turns bus traffic into one-cycle event pulses: an address load, each received data byte, the start of a read transfer, each master acknowledge during a read, and the START and STOP conditions. From these pulses the block keeps the shared address pointer, which it drives onto the memory read port. During a write it gathers the data bytes in a page-sized staging buffer.

On STOP, the block copies the staged bytes into a synchronous byte-wide memory, one byte at a time. It holds `busy` high for the whole copy, so the front-end can refuse to acknowledge new traffic while the copy runs. The write-protect input is sampled only at the STOP that ends a write. When protection is active, nothing is written and the block is ready again at once, but the pointer still shows every byte that was sent.

The front-end must present one event per clock. The per-byte write time is a parameter counted in clocks.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, `busy` and `mem_we` are low and the pointer on `mem_ra` is 0.
- R2: `addr_ld` loads the pointer from `addr_in`. Each data byte in a write transfer advances only the low 6 pointer bits, so the pointer wraps to the start of the 64-byte page: 0x007F becomes 0x0040.
- R3: A data byte is staged in the slot given by the low 6 pointer bits. When more than 64 bytes arrive, the earliest slots are overwritten. Only slots that received data in the current transfer are written. The set of filled slots is cleared by every `addr_ld`.
- R4: A memory write happens only when `ev_stop` ends a write transfer that staged at least one byte. If `ev_start` ends the transfer instead, or if there is no transfer, nothing is written.
- R5: When `wp` is high in the STOP cycle, no byte is written and `busy` stays low. The pointer still shows the in-page advance made by the bytes sent.
- R6: A change of `wp` after the STOP cycle has no effect on a commit that has already begun.
- R7: `busy` rises in the cycle after STOP and stays high for exactly n×T_WR cycles, where n is the number of staged slots. One `mem_we` pulse opens each T_WR-cycle interval. Slots are written in ascending order from the page start, at address {page, slot}, with the staged data.
- R8: In a read transfer, begun by `rd_begin`, the pointer increments by one on each `rd_ack` and once more at `ev_stop`. It rolls over from 0x7FFF to 0x0000.
- R9: The sequence address load, START, read begin, STOP leaves the pointer one past the loaded address.
- R10: While `busy` is high, every event input is ignored: the pointer does not change and no byte is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_ld | input | 1 | Pulse: address bytes received, begins a write transfer |
| addr_in | input | 15 | Address that goes with `addr_ld` |
| wr_vld | input | 1 | Pulse: data byte received |
| wr_byte | input | 8 | Data byte that goes with `wr_vld` |
| rd_begin | input | 1 | Pulse: read control byte accepted |
| rd_ack | input | 1 | Pulse: master acknowledged a read byte |
| ev_start | input | 1 | Pulse: START or repeated START seen |
| ev_stop | input | 1 | Pulse: STOP seen |
| wp | input | 1 | Write protect, active high, sampled at STOP |
| busy | output | 1 | Commit in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_wa | output | 15 | Memory write address |
| mem_wd | output | 8 | Memory write data |
| mem_ra | output | 15 | Memory read address (the pointer) |

## Verification
The bench drives each event pulse for one cycle and samples on the falling edge after the rising edge that consumed it. The pointer on `mem_ra` is therefore compared one cycle after its event. `busy` is first seen high on the falling edge right after the STOP pulse, and the bench counts the falling edges while it stays high, comparing the count with n×T_WR. The first `mem_we` appears in that same first busy cycle and the next one T_WR cycles later. A scoreboard monitor compares every strobe at the falling edge with the next expected {address, data} pair, reports any strobe it did not expect, and reports any expected write that is still missing when `busy` falls.

// File: rtl/pgwr_pkg.sv
// Shared types for the page-buffered write engine.
package pgwr_pkg;
    // Pointer update selected for one cycle
    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_LOAD,
        PTR_STEP_PAGE,
        PTR_STEP_FULL
    } ptr_op_e;

    // Kind of bus transfer in progress
    typedef enum logic [1:0] {
        XF_IDLE,
        XF_WRITE,
        XF_READ
    } xfer_e;
endpackage

// File: rtl/pgwr_pointer.sv
// Address pointer register.
// Loads, steps within a page (the low PW bits wrap), or steps over the full width (rolls over to 0).
// Assumes the caller issues one operation per cycle.
module pgwr_pointer
    import pgwr_pkg::*;
#(
    parameter int AW = 15,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ptr_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] ptr
);
    // Apply the selected pointer operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            case (op)
                PTR_LOAD:      ptr <= load_val;
                PTR_STEP_PAGE: ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                PTR_STEP_FULL: ptr <= ptr + AW'(1);
                default:       ptr <= ptr;
            endcase
        end
    end
endmodule

// File: rtl/pgwr_buffer.sv
// Page staging buffer with a per-slot filled mask.
// Gives the lowest filled slot to the commit sequencer.
// Assumes that clearing all slots and clearing one slot never happen in the same cycle.
module pgwr_buffer #(
    parameter int PW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          done_en,
    input  logic [PW-1:0] done_idx,
    output logic [PW-1:0] next_idx,
    output logic [DW-1:0] next_data,
    output logic          any_pending
);
    localparam int SLOTS = 1 << PW;

    logic [DW-1:0]    store [SLOTS];
    logic [SLOTS-1:0] filled;
    logic [SLOTS-1:0] filled_nx;

    // Data storage: needs no reset, because the filled mask guards every read
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    // Next-state of the filled mask
    always_comb begin
        filled_nx = filled;
        if (clr_all) filled_nx = '0;
        if (wr_en)   filled_nx[wr_idx] = 1'b1;
        if (done_en) filled_nx[done_idx] = 1'b0;
    end

    // Filled mask register
    always_ff @(posedge clk) begin
        if (!rst_n) filled <= '0;
        else        filled <= filled_nx;
    end

    // Find the lowest filled slot
    always_comb begin
        next_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (filled[i]) next_idx = PW'(i);
        end
    end

    assign any_pending = |filled;
    assign next_data   = store[next_idx];
endmodule

// File: rtl/pgwr_commit.sv
// Commit sequencer.
// After go, writes one filled slot every T_WR cycles until none is left.
// Assumes T_WR >= 2, so that a slot cleared on the write cycle is seen before the interval ends.
module pgwr_commit #(
    parameter int T_WR = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic any_pending,
    output logic busy,
    output logic we
);
    localparam int TW = (T_WR > 1) ? $clog2(T_WR) : 1;
    localparam logic [TW-1:0] LAST = TW'(T_WR - 1);

    logic          run;
    logic [TW-1:0] timer;

    // Run flag and per-byte interval timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            timer <= '0;
        end else if (!run) begin
            timer <= '0;
            if (go && any_pending) run <= 1'b1;
        end else if (timer == LAST) begin
            timer <= '0;
            if (!any_pending) run <= 1'b0;
        end else begin
            timer <= timer + TW'(1);
        end
    end

    assign busy = run;
    assign we   = run && (timer == '0);
endmodule

// File: rtl/pgwr_engine.sv
// Page-buffered write and pointer engine (top).
// Decodes the front-end event pulses, drives the pointer, staging buffer and commit sequencer.
// Assumes at most one event pulse per cycle, and that the front-end stops acknowledging while busy is high.
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int AW   = 15,
    parameter int DW   = 8,
    parameter int PW   = 6,
    parameter int T_WR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_byte,
    input  logic          rd_begin,
    input  logic          rd_ack,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          wp,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_wa,
    output logic [DW-1:0] mem_wd,
    output logic [AW-1:0] mem_ra
);
    xfer_e         xf, xf_nx;
    ptr_op_e       op;
    logic          stage_en, clr_all, go, any_pending;
    logic [AW-1:0] ptr;
    logic [PW-1:0] slot;
    logic [DW-1:0] slot_data;

    // Event decode: picks the pointer operation, staging and commit start
    always_comb begin
        op       = PTR_HOLD;
        stage_en = 1'b0;
        clr_all  = 1'b0;
        go       = 1'b0;
        xf_nx    = xf;
        if (!busy) begin
            if (addr_ld) begin
                op      = PTR_LOAD;
                clr_all = 1'b1;
                xf_nx   = XF_WRITE;
            end else if (wr_vld && xf == XF_WRITE) begin
                op       = PTR_STEP_PAGE;
                stage_en = 1'b1;
            end else if (rd_begin) begin
                xf_nx = XF_READ;
            end else if (rd_ack && xf == XF_READ) begin
                op = PTR_STEP_FULL;
            end else if (ev_stop) begin
                if (xf == XF_WRITE && !wp) go = 1'b1;
                if (xf == XF_READ) op = PTR_STEP_FULL;
                xf_nx = XF_IDLE;
            end else if (ev_start) begin
                xf_nx = XF_IDLE;
            end
        end
    end

    // Transfer-kind register
    always_ff @(posedge clk) begin
        if (!rst_n) xf <= XF_IDLE;
        else        xf <= xf_nx;
    end

    pgwr_pointer #(.AW(AW), .PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_val (addr_in),
        .ptr      (ptr)
    );

    pgwr_buffer #(.PW(PW), .DW(DW)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (clr_all),
        .wr_en       (stage_en),
        .wr_idx      (ptr[PW-1:0]),
        .wr_data     (wr_byte),
        .done_en     (mem_we),
        .done_idx    (slot),
        .next_idx    (slot),
        .next_data   (slot_data),
        .any_pending (any_pending)
    );

    pgwr_commit #(.T_WR(T_WR)) u_cmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .any_pending (any_pending),
        .busy        (busy),
        .we          (mem_we)
    );

    assign mem_wa = {ptr[AW-1:PW], slot};
    assign mem_wd = slot_data;
    assign mem_ra = ptr;
endmodule

// File: rtl/pgwr_engine_chk.sv
// Property checker for pgwr_engine, attached through bind.
// Relates the event pulses to busy, the write strobe and the pointer.
module pgwr_engine_chk #(
    parameter int AW   = 15,
    parameter int PW   = 6,
    parameter int T_WR = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_ld,
    input logic          wr_vld,
    input logic          rd_begin,
    input logic          rd_ack,
    input logic          ev_start,
    input logic          ev_stop,
    input logic          wp,
    input logic          busy,
    input logic          mem_we,
    input logic [AW-1:0] mem_ra
);
    logic [31:0] gap;
    logic        chain;

    // Counts the cycles since the last strobe within one busy period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap   <= '0;
            chain <= 1'b0;
        end else if (mem_we) begin
            gap   <= '0;
            chain <= 1'b1;
        end else if (busy) begin
            gap <= gap + 32'd1;
        end else begin
            chain <= 1'b0;
        end
    end

    // R7: a write strobe only appears while busy is high
    assert_we_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: successive strobes of one commit are T_WR cycles apart
    assert_we_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && chain) |-> (gap == 32'(T_WR - 1)));

    // R5: busy rises only after an unprotected STOP
    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(ev_stop) && !$past(wp)));

    // R10: the pointer is frozen while a commit runs
    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_ra));

    // R2: a data byte never moves the pointer off its page
    assert_page_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !addr_ld && !rd_begin && !rd_ack && !ev_start && !ev_stop)
        |=> (mem_ra[AW-1:PW] == $past(mem_ra[AW-1:PW])));
endmodule

bind pgwr_engine pgwr_engine_chk #(.AW(AW), .PW(PW), .T_WR(T_WR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_ld  (addr_ld),
    .wr_vld   (wr_vld),
    .rd_begin (rd_begin),
    .rd_ack   (rd_ack),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .wp       (wp),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_ra   (mem_ra)
);

// File: tb/test_pgwr_engine.sv
module test_pgwr_engine;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int T_WR = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_ld = 0, wr_vld = 0, rd_begin = 0, rd_ack = 0, ev_start = 0, ev_stop = 0, wp = 0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] wr_byte = '0;
    logic busy, mem_we;
    logic [AW-1:0] mem_wa, mem_ra;
    logic [DW-1:0] mem_wd;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [AW+DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    pgwr_engine #(.AW(AW), .DW(DW), .PW(6), .T_WR(T_WR)) i_pgwr_engine (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .wr_vld(wr_vld), .wr_byte(wr_byte), .rd_begin(rd_begin), .rd_ack(rd_ack),
        .ev_start(ev_start), .ev_stop(ev_stop), .wp(wp), .busy(busy),
        .mem_we(mem_we), .mem_wa(mem_wa), .mem_wd(mem_wd), .mem_ra(mem_ra)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares every write strobe with the next expected item
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4/R5: unexpected write actual 0x%0h expected none", {mem_wa, mem_wd});
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                if ({mem_wa, mem_wd} !== e) begin
                    errors++;
                    $display("FAIL R7: write actual 0x%0h expected 0x%0h", {mem_wa, mem_wd}, e);
                end
            end
        end
    end

    task automatic push_exp(input int a, input int d);
        exp_q.push_back({AW'(a), DW'(d)});
    endtask

    task automatic p_addr(input int a);
        @(negedge clk); addr_ld = 1; addr_in = AW'(a);
        @(negedge clk); addr_ld = 0;
    endtask
    task automatic p_byte(input int d);
        @(negedge clk); wr_vld = 1; wr_byte = DW'(d);
        @(negedge clk); wr_vld = 0;
    endtask
    task automatic p_rdb();
        @(negedge clk); rd_begin = 1; @(negedge clk); rd_begin = 0;
    endtask
    task automatic p_ack();
        @(negedge clk); rd_ack = 1; @(negedge clk); rd_ack = 0;
    endtask
    task automatic p_start();
        @(negedge clk); ev_start = 1; @(negedge clk); ev_start = 0;
    endtask
    task automatic p_stop();
        @(negedge clk); ev_stop = 1; @(negedge clk); ev_stop = 0;
    endtask

    // Counts the busy cycles starting at the current falling edge
    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic expect_commit(input int nbytes, input string req);
        int n;
        busy_len(n);
        chk(n == nbytes * T_WR, req, n, nbytes * T_WR);
        chk(exp_q.size() == 0, "R7 all writes seen", exp_q.size(), 0);
    endtask

    task automatic idle_no_busy(input string req);
        int seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(mem_we == 0, "R1 we", mem_we, 0);
        chk(mem_ra == 0, "R1 ptr", mem_ra, 0);

        // R2 R7 single byte write
        p_addr('h0123);
        chk(mem_ra == 'h0123, "R2 load", mem_ra, 'h0123);
        p_byte('hA5);
        chk(mem_ra == 'h0124, "R2 step", mem_ra, 'h0124);
        push_exp('h0123, 'hA5);
        p_stop();
        chk(busy == 1, "R7 busy rises after STOP", busy, 1);
        expect_commit(1, "R7 busy length 1 byte");

        // R3 mask cleared on a new transfer: only the new slot is written
        p_addr('h0120);
        p_byte('h3C);
        push_exp('h0120, 'h3C);
        p_stop();
        expect_commit(1, "R3 mask cleared");

        // R2 page wrap 0x007F -> 0x0040; R7 ascending slot order
        p_addr('h007F);
        p_byte('h11);
        chk(mem_ra == 'h0040, "R2 wrap", mem_ra, 'h0040);
        p_byte('h22);
        push_exp('h0040, 'h22);
        push_exp('h007F, 'h11);
        p_stop();
        expect_commit(2, "R7 busy length 2 bytes");
        chk(mem_ra == 'h0041, "R2 ptr after wrap", mem_ra, 'h0041);

        // R3 overflow: 66 bytes, the first two slots are overwritten
        p_addr('h0200);
        for (int i = 0; i < 66; i++) p_byte(i);
        for (int i = 0; i < 64; i++) push_exp('h0200 + i, (i < 2) ? i + 64 : i);
        p_stop();
        expect_commit(64, "R3 R7 busy length 64 bytes");
        chk(mem_ra == 'h0202, "R3 ptr after overflow", mem_ra, 'h0202);

        // R5 write protect at STOP
        p_addr('h0300);
        p_byte(1); p_byte(2); p_byte(3);
        @(negedge clk); wp = 1; ev_stop = 1;
        @(negedge clk); ev_stop = 0;
        chk(busy == 0, "R5 busy low", busy, 0);
        wp = 0;
        idle_no_busy("R5 no commit");
        chk(mem_ra == 'h0303, "R5 ptr advanced", mem_ra, 'h0303);

        // R6 wp raised right after STOP
        p_addr('h0310);
        p_byte('h5A);
        push_exp('h0310, 'h5A);
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0; wp = 1;
        expect_commit(1, "R6 commit despite later wp");
        wp = 0;

        // R4 START ends the write: no commit, even with a later STOP
        p_addr('h0400);
        p_byte('h77);
        p_start();
        p_stop();
        idle_no_busy("R4 no commit after START");
        chk(mem_ra == 'h0401, "R4 ptr", mem_ra, 'h0401);

        // R8 sequential read: +1 per ACK and +1 at STOP
        p_rdb();
        p_ack();
        chk(mem_ra == 'h0402, "R8 ack step", mem_ra, 'h0402);
        p_ack();
        p_stop();
        chk(mem_ra == 'h0404, "R8 stop step", mem_ra, 'h0404);

        // R8 rollover from the last address
        p_addr('h7FFF);
        p_start();
        p_rdb();
        p_stop();
        chk(mem_ra == 'h0000, "R8 rollover", mem_ra, 0);
        idle_no_busy("R4 no commit on address only");

        // R9 random read
        p_addr('h1234);
        p_start();
        p_rdb();
        p_stop();
        chk(mem_ra == 'h1235, "R9 random read ptr", mem_ra, 'h1235);

        // R10 events ignored while busy
        p_addr('h0500);
        p_byte('h99);
        push_exp('h0500, 'h99);
        p_stop();
        p_addr('h5555);
        p_byte('h66);
        p_ack();
        chk(mem_ra == 'h0501, "R10 ptr frozen", mem_ra, 'h0501);
        busy_len(n);
        chk(exp_q.size() == 0, "R10 single write", exp_q.size(), 0);
        p_stop();
        idle_no_busy("R10 nothing staged while busy");
        chk(mem_ra == 'h0501, "R10 ptr after commit", mem_ra, 'h0501);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule